// File: doc/BRIEF.md
# Interrupt Line Remapping Network

This block sits between the on-chip bus interrupt sources and a priority interrupt controller. Each of the 64 bus interrupt lines has its own map entry, set by software through a small register port. The entry names the controller input that the line should drive. Targets 2 to 15 are the prioritized primary numbers. Targets 16 to 31 form the extended group, which the controller folds onto its reserved number 1.

The output is a 32-bit vector with one bit per interrupt number. Every line whose entry names a given number is ORed into that number's bit, so several sources can share one controller input. An entry holding 0 or 1 leaves its line disconnected. Nothing is ever driven onto bits 0 and 1.

The map is held in registers. The path from the input lines to the output vector is purely combinational, so routing adds no cycle of latency. Pending, masking and priority logic belong to the controller that follows.

Top module: `irq_remap_net`

## Requirements
- R1: After reset every map entry reads back as 0, and `irq_out` is all zero whatever `bus_irq` holds.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the entry of line `cfg_addr` at the clock edge. From the next cycle, `cfg_rdata` returns that value whenever `cfg_addr` selects the line.
- R3: When line i has an entry value t with 2 ≤ t ≤ 31, `irq_out[t]` follows `bus_irq[i]` in the same cycle, with no register on the path.
- R4: A line whose entry value is 0 or 1 drives no bit of `irq_out`.
- R5: `irq_out[0]` and `irq_out[1]` are always 0.
- R6: `irq_out[t]` is the OR of `bus_irq` over all lines whose entry equals t.
- R7: A single asserted line raises exactly one bit of `irq_out`, the one its entry names, and never any other bit.
- R8: While `cfg_we` is low, no map entry changes, whatever `cfg_addr` and `cfg_wdata` hold.
- R9: Rewriting a line's entry moves its request to the new number from the cycle after the write. The old number is released at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_irq | input | 64 | Bus interrupt lines, bit i is line i |
| cfg_we | input | 1 | Map entry write strobe |
| cfg_addr | input | 6 | Line index for both write and read-back |
| cfg_wdata | input | 5 | Target interrupt number to store |
| cfg_rdata | output | 5 | Stored target of the line at `cfg_addr` |
| irq_out | output | 32 | Mapped interrupt vector, bit t is interrupt number t |

## Verification
The routing is tried in several ways. Single isolated lines separate a correct target from a neighbouring or duplicated bit. Groups of lines that share one number are driven in every subset, which separates a real OR from last-writer-wins routing. Lines parked on entry values 0 and 1, the extreme lines 0 and 63, and the extreme targets 2 and 31 cover the edges of the decode. Random map writes interleaved with random line patterns are then compared every cycle against a behavioural model. This run catches stale entries, skipped writes and writes made with the strobe low.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;

  localparam int IRQ_SEL_W  = 5;
  localparam int IRQ_OUT_W  = 1 << IRQ_SEL_W;
  localparam int FIRST_LIVE = 2;

  typedef logic [IRQ_SEL_W-1:0] irq_sel_t;
  typedef logic [IRQ_OUT_W-1:0] irq_vec_t;

  // An entry below FIRST_LIVE leaves its line disconnected.
  function automatic logic sel_is_live(input irq_sel_t s);
    return (int'(s) >= FIRST_LIVE);
  endfunction

  // One-hot target mask for a map entry; zero when the entry is parked.
  function automatic irq_vec_t sel_to_mask(input irq_sel_t s);
    irq_vec_t m;
    m = '0;
    if (sel_is_live(s)) m[s] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_map_table.sv
module irq_map_table
  import irq_remap_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int ADDR_W  = $clog2(N_LINES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  irq_sel_t                     wdata,
  output irq_sel_t                     rdata,
  output logic [N_LINES*IRQ_SEL_W-1:0] map_flat
);

  irq_sel_t entry_q [N_LINES];

  for (genvar i = 0; i < N_LINES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                       entry_q[i] <= '0;
      else if (we && (int'(addr) == i))              entry_q[i] <= wdata;
    end
    assign map_flat[i*IRQ_SEL_W +: IRQ_SEL_W] = entry_q[i];
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) < N_LINES) rdata = entry_q[addr];
  end

endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode
  import irq_remap_pkg::*;
(
  input  irq_sel_t sel,
  output irq_vec_t hit
);

  assign hit = sel_to_mask(sel);

endmodule

// File: rtl/irq_or_reduce.sv
module irq_or_reduce
  import irq_remap_pkg::*;
#(
  parameter int N_LINES = 64
) (
  input  logic [N_LINES-1:0]           lines,
  input  logic [N_LINES*IRQ_OUT_W-1:0] hit_flat,
  output irq_vec_t                     vec
);

  always_comb begin
    vec = '0;
    for (int i = 0; i < N_LINES; i++) begin
      vec = vec | (hit_flat[i*IRQ_OUT_W +: IRQ_OUT_W] & {IRQ_OUT_W{lines[i]}});
    end
  end

endmodule

// File: rtl/irq_remap_net.sv
module irq_remap_net
  import irq_remap_pkg::*;
#(
  parameter int N_LINES = 64,
  localparam int ADDR_W = $clog2(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LINES-1:0]   bus_irq,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [IRQ_SEL_W-1:0] cfg_wdata,
  output logic [IRQ_SEL_W-1:0] cfg_rdata,
  output logic [IRQ_OUT_W-1:0] irq_out
);

  // Named internal wires, observed by the bound checker.
  logic [N_LINES*IRQ_SEL_W-1:0] map_flat;
  logic [N_LINES*IRQ_OUT_W-1:0] hit_flat;

  irq_map_table #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .map_flat (map_flat)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_dec
    irq_line_decode u_dec (
      .sel (map_flat[i*IRQ_SEL_W +: IRQ_SEL_W]),
      .hit (hit_flat[i*IRQ_OUT_W +: IRQ_OUT_W])
    );
  end

  irq_or_reduce #(.N_LINES(N_LINES)) u_or (
    .lines    (bus_irq),
    .hit_flat (hit_flat),
    .vec      (irq_out)
  );

endmodule

// File: rtl/irq_remap_chk.sv
module irq_remap_chk
  import irq_remap_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int ADDR_W  = $clog2(N_LINES)
) (
  input logic                         clk,
  input logic                         rst,
  input logic [N_LINES-1:0]           bus_irq,
  input logic                         cfg_we,
  input logic [ADDR_W-1:0]            cfg_addr,
  input logic [IRQ_SEL_W-1:0]         cfg_wdata,
  input logic [IRQ_OUT_W-1:0]         irq_out,
  input logic [N_LINES*IRQ_SEL_W-1:0] map_flat,
  input logic [N_LINES*IRQ_OUT_W-1:0] hit_flat
);

  logic              last_we;
  logic [ADDR_W-1:0] last_addr;
  irq_sel_t          last_data;

  always_ff @(posedge clk) begin
    last_we   <= cfg_we && !rst;
    last_addr <= cfg_addr;
    last_data <= cfg_wdata;
  end

  irq_sel_t landed;
  always_comb begin
    landed = '0;
    for (int i = 0; i < N_LINES; i++)
      if (int'(last_addr) == i) landed = map_flat[i*IRQ_SEL_W +: IRQ_SEL_W];
  end

  p_clear_r1: assert property (@(posedge clk) $past(rst) |-> (map_flat == '0));

  p_wr_lands_r2: assert property (@(posedge clk) disable iff (rst)
    last_we |-> (landed == last_data));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(map_flat));

  p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out[1:0] == 2'b00);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_flat[i*IRQ_OUT_W +: IRQ_OUT_W]));

    p_parked_r4: assert property (@(posedge clk) disable iff (rst)
      (map_flat[i*IRQ_SEL_W +: IRQ_SEL_W] < IRQ_SEL_W'(FIRST_LIVE))
        |-> (hit_flat[i*IRQ_OUT_W +: IRQ_OUT_W] == '0));

    p_drive_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_irq[i] && (map_flat[i*IRQ_SEL_W +: IRQ_SEL_W] >= IRQ_SEL_W'(FIRST_LIVE)))
        |-> irq_out[map_flat[i*IRQ_SEL_W +: IRQ_SEL_W]]);
  end

endmodule

bind irq_remap_net irq_remap_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_irq   (bus_irq),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .irq_out   (irq_out),
  .map_flat  (map_flat),
  .hit_flat  (hit_flat)
);

// File: tb/sim_irq_remap_net.sv
`timescale 1ns/1ps
module sim_irq_remap_net;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] bus_irq = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic [31:0] irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit live_cmp = 0;

  always #5 clk = ~clk;

  irq_remap_net u0 (
    .clk(clk), .rst(rst), .bus_irq(bus_irq), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out)
  );

  // Behavioural reference: an array of targets, updated like the spec says.
  int unsigned mdl [64];

  always @(posedge clk) begin
    if (rst) begin
      foreach (mdl[k]) mdl[k] = 0;
    end else if (cfg_we) begin
      mdl[cfg_addr] = cfg_wdata;
    end
  end

  function automatic logic [31:0] expect_vec();
    logic [31:0] v = '0;
    foreach (mdl[k]) if (mdl[k] >= 2 && bus_irq[k]) v[mdl[k]] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && live_cmp && !done) begin
      chk(irq_out === expect_vec(), "R6", irq_out, expect_vec());
      chk(cfg_rdata === 5'(mdl[cfg_addr]), "R2", 32'(cfg_rdata), mdl[cfg_addr]);
      chk(irq_out[1:0] === 2'b00, "R5", 32'(irq_out[1:0]), 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    tick();
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 5'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: everything reads zero after reset, no routing with all lines high
    for (int a = 0; a < 64; a++) begin
      cfg_addr = 6'(a);
      @(negedge clk);
      chk(cfg_rdata === 5'd0, "R1", 32'(cfg_rdata), 0);
      tick();
    end
    bus_irq = '1;
    @(negedge clk);
    chk(irq_out === 32'h0, "R1", irq_out, 0);
    tick();
    bus_irq = '0;
    live_cmp = 1;

    // R4: parked entries 0 and 1
    wr(5, 1);
    wr(6, 0);
    cfg_addr = 6'd5;
    bus_irq = 64'h60;
    @(negedge clk);
    chk(irq_out === 32'h0, "R4", irq_out, 0);
    chk(cfg_rdata === 5'd1, "R2", 32'(cfg_rdata), 1);
    tick();
    bus_irq = '0;

    // R7 / R3: single line, exact single bit, same cycle
    wr(7, 20);
    bus_irq = 64'h80;
    @(negedge clk);
    chk(irq_out === (32'h1 << 20), "R7", irq_out, 32'h1 << 20);
    tick();
    bus_irq = '0;
    @(negedge clk);
    chk(irq_out === 32'h0, "R3", irq_out, 0);
    tick();

    // R9: move line 7 from 20 to 9
    bus_irq = 64'h80;
    wr(7, 9);
    @(negedge clk);
    chk(irq_out === (32'h1 << 9), "R9", irq_out, 32'h1 << 9);

    // R8: strobe low, junk on address and data
    tick();
    cfg_we = 1'b0; cfg_addr = 6'd7; cfg_wdata = 5'd30;
    tick();
    @(negedge clk);
    chk(cfg_rdata === 5'd9, "R8", 32'(cfg_rdata), 9);
    chk(irq_out === (32'h1 << 9), "R8", irq_out, 32'h1 << 9);
    tick();
    bus_irq = '0;

    // R6: three lines share number 14, every subset
    wr(10, 14); wr(11, 14); wr(12, 14);
    for (int s = 0; s < 8; s++) begin
      bus_irq = 64'(s) << 10;
      @(negedge clk);
      chk(irq_out === ((s != 0) ? (32'h1 << 14) : 32'h0), "R6", irq_out,
          (s != 0) ? (32'h1 << 14) : 32'h0);
      tick();
    end
    bus_irq = '0;

    // R3: extreme lines and extreme targets
    wr(63, 31);
    wr(0, 2);
    bus_irq = 64'h8000_0000_0000_0001;
    @(negedge clk);
    chk(irq_out === 32'h8000_0004, "R3", irq_out, 32'h8000_0004);
    tick();
    bus_irq = '0;

    // Random map writes and line patterns, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      cfg_we    = ($urandom_range(0, 3) == 0);
      cfg_addr  = 6'($urandom);
      cfg_wdata = 5'($urandom);
      bus_irq   = {$urandom, $urandom} & {$urandom, $urandom};
      tick();
    end
    cfg_we = 1'b0;
    tick();
    finish_run();
  end

endmodule